// File: doc/BRIEF.md
# Behavior Aggregate Traffic Classifier

This block gives every packet descriptor a forwarding class (one of eight) and a loss-priority bit. Header parsing is done before it. The block takes a descriptor that has already been parsed. The descriptor holds:

- a flag that says whether the traffic is IP or Layer 2,
- the VLAN tag count,
- the priority bits of the outer and inner tags,
- the precedence field,
- the DSCP field.

Each logical interface has a small configuration word that chooses how its traffic is classified:

- One mode places every packet in a single configured class.
- Another mode uses the 802.1p tag priority for all traffic.
- Two mixed modes use the tag priority for Layer 2 frames and, for IP packets, either the precedence table or the DSCP table.

All lookup tables and the per-interface words are loaded through one register write port. A multifield result from a filter stage travels with the descriptor. It can replace the class, the loss priority, or both. The classifier is a two-stage pipeline with valid/ready handshakes on both sides. It accepts one descriptor per cycle and returns a record that carries the interface number, the class and the loss priority.

Top module: `ba_classifier`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. Every table entry and every interface word is zero, so each interface classifies to class 0 with loss priority 0.
- R2: A descriptor accepted at clock edge k appears on the output after edge k+1. A new descriptor can be accepted every cycle. While `out_valid` is 1 and `out_ready` is 0, the output record holds its value and `in_ready` is 0.
- R3: In fixed mode (mode code 0), the class is the class field of the interface word and the loss priority is 0, whatever the header holds.
- R4: In 802.1p mode (mode code 1), all traffic, IP or not, is looked up in the 8-entry priority table. The index is the outer tag's priority when the inner-select bit is 0.
- R5: When the inner-select bit is 1 and the frame has two or more tags, the inner tag's priority is used as the 802.1p index.
- R6: In mixed-precedence mode (mode code 2), IP packets are looked up in the 8-entry precedence table. Layer 2 frames use the 802.1p table.
- R7: In mixed-DSCP mode (mode code 3), IP packets are looked up in the 64-entry DSCP table. Layer 2 frames use the 802.1p table.
- R8: In these two cases the result is the interface word's class field with loss priority 0:
  - an 802.1p lookup is needed but the frame has no tag;
  - the inner tag is selected but the frame has fewer than two tags.
- R9: The multifield override acts after the table lookup:
  - When `in_mf_cls_en` is 1, `in_mf_cls` replaces the class.
  - When `in_mf_lp_en` is 1, `in_mf_lp` replaces the loss priority.
  - The two enables act independently.
- R10: The write port decodes `wr_sel` as follows:
  - 0 writes the 802.1p table, at `wr_idx[2:0]`.
  - 1 writes the precedence table, at `wr_idx[2:0]`.
  - 2 writes the DSCP table, at `wr_idx[5:0]`.
  - For these three tables, `wr_data[2:0]` is the class and `wr_data[3]` is the loss priority.
  - 3 writes the word of interface `wr_idx`. In that word, `wr_data[2:0]` is the class, `wr_data[3]` is inner-select and `wr_data[5:4]` is the mode.
- R11: A table write can happen in the cycle in which a descriptor in the first stage reads that same entry. The descriptor then gets the contents from before the write. Later descriptors get the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for tables and interface words |
| wr_sel | input | 2 | Write target: 0 tag-priority, 1 precedence, 2 DSCP, 3 interface word |
| wr_idx | input | 6 | Entry or interface index |
| wr_data | input | 6 | Entry value or interface word |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Descriptor accepted when high with `in_valid` |
| in_if | input | 2 | Logical interface number |
| in_is_ip | input | 1 | 1 for an IP packet, 0 for Layer 2 traffic |
| in_tags | input | 2 | Number of VLAN tags (2 or 3 means dual-tagged) |
| in_pcp_outer | input | 3 | Outer tag priority |
| in_pcp_inner | input | 3 | Inner tag priority |
| in_prec | input | 3 | IP precedence |
| in_dscp | input | 6 | DSCP |
| in_mf_cls_en | input | 1 | Override the class |
| in_mf_cls | input | 3 | Override class value |
| in_mf_lp_en | input | 1 | Override the loss priority |
| in_mf_lp | input | 1 | Override loss-priority value |
| out_valid | output | 1 | Result record present |
| out_ready | input | 1 | Consumer takes the record |
| out_if | output | 2 | Interface number of the record |
| out_cls | output | 3 | Forwarding class |
| out_lp | output | 1 | Loss priority |

## Verification
A table write and a lookup of the same entry can fall in one cycle. The bench provokes this by launching a descriptor that indexes 802.1p entry 5. In the very next cycle, while that descriptor sits in the first stage, it rewrites entry 5. The bench judges the outcome in two steps. The descriptor in flight must report the old class and loss priority. A second descriptor sent afterwards must report the new ones.

// File: rtl/bac_pkg.sv
package bac_pkg;
   localparam int CLS_W  = 3;
   localparam int PCP_W  = 3;
   localparam int DSCP_W = 6;
   localparam int ENT_W  = CLS_W + 1;

   localparam logic [1:0] WSEL_DOT1P = 2'd0;
   localparam logic [1:0] WSEL_PREC  = 2'd1;
   localparam logic [1:0] WSEL_DSCP  = 2'd2;
   localparam logic [1:0] WSEL_CFG   = 2'd3;

   typedef enum logic [1:0] {
      MODE_FIXED    = 2'd0,
      MODE_DOT1P    = 2'd1,
      MODE_MIX_PREC = 2'd2,
      MODE_MIX_DSCP = 2'd3
   } bac_mode_e;

   typedef enum logic [1:0] {
      SRC_DIRECT = 2'd0,
      SRC_DOT1P  = 2'd1,
      SRC_PREC   = 2'd2,
      SRC_DSCP   = 2'd3
   } bac_src_e;

   typedef struct packed {
      bac_mode_e        mode;
      logic             inner;
      logic [CLS_W-1:0] cls;
   } bac_cfg_t;

   typedef struct packed {
      logic             lp;
      logic [CLS_W-1:0] cls;
   } bac_ent_t;

   localparam int CFG_W = $bits(bac_cfg_t);
endpackage

// File: rtl/bac_lut.sv
module bac_lut #(
   parameter int IDX_W  = 3,
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [IDX_W-1:0]  w_idx,
   input  logic [DATA_W-1:0] w_data,
   input  logic [IDX_W-1:0]  r_idx,
   output logic [DATA_W-1:0] r_data
);
   localparam int DEPTH = 1 << IDX_W;

   initial begin
      assert (IDX_W >= 1 && IDX_W <= 8) else $error("bac_lut: IDX_W out of range");
      assert (DATA_W >= 1) else $error("bac_lut: DATA_W must be positive");
   end

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we) begin
         mem_q[w_idx] <= w_data;
      end
   end

   // read is combinational on the stored value, so a write in the same
   // cycle is seen only by later reads
   assign r_data = mem_q[r_idx];
endmodule

// File: rtl/bac_keysel.sv
module bac_keysel
   import bac_pkg::*;
(
   input  bac_cfg_t              cfg,
   input  logic                  is_ip,
   input  logic [1:0]            tags,
   input  logic [PCP_W-1:0]      pcp_outer,
   input  logic [PCP_W-1:0]      pcp_inner,
   input  logic [PCP_W-1:0]      prec,
   input  logic [DSCP_W-1:0]     dscp,
   output bac_src_e              src,
   output logic [DSCP_W-1:0]     idx,
   output logic [CLS_W-1:0]      direct_cls
);
   logic             tag_missing;
   bac_src_e         pcp_src;
   logic [PCP_W-1:0] pcp_pick;

   always_comb begin
      tag_missing = (tags == 2'd0) || (cfg.inner && (tags < 2'd2));
      pcp_pick    = cfg.inner ? pcp_inner : pcp_outer;
      pcp_src     = tag_missing ? SRC_DIRECT : SRC_DOT1P;
   end

   always_comb begin
      direct_cls = cfg.cls;
      src        = pcp_src;
      idx        = DSCP_W'(pcp_pick);
      unique case (cfg.mode)
         MODE_FIXED: begin
            src = SRC_DIRECT;
            idx = '0;
         end
         MODE_DOT1P: ;
         MODE_MIX_PREC: if (is_ip) begin
            src = SRC_PREC;
            idx = DSCP_W'(prec);
         end
         MODE_MIX_DSCP: if (is_ip) begin
            src = SRC_DSCP;
            idx = dscp;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/ba_classifier.sv
module ba_classifier
   import bac_pkg::*;
#(
   parameter int IF_CNT = 4,
   localparam int IF_W  = $clog2(IF_CNT),
   localparam int WR_W  = CFG_W
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wr_en,
   input  logic [1:0]           wr_sel,
   input  logic [DSCP_W-1:0]    wr_idx,
   input  logic [WR_W-1:0]      wr_data,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [IF_W-1:0]      in_if,
   input  logic                 in_is_ip,
   input  logic [1:0]           in_tags,
   input  logic [PCP_W-1:0]     in_pcp_outer,
   input  logic [PCP_W-1:0]     in_pcp_inner,
   input  logic [PCP_W-1:0]     in_prec,
   input  logic [DSCP_W-1:0]    in_dscp,
   input  logic                 in_mf_cls_en,
   input  logic [CLS_W-1:0]     in_mf_cls,
   input  logic                 in_mf_lp_en,
   input  logic                 in_mf_lp,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [IF_W-1:0]      out_if,
   output logic [CLS_W-1:0]     out_cls,
   output logic                 out_lp
);
   initial begin
      assert (IF_CNT >= 2 && (IF_CNT & (IF_CNT - 1)) == 0)
         else $error("ba_classifier: IF_CNT must be a power of two >= 2");
      assert (IF_W <= DSCP_W) else $error("ba_classifier: too many interfaces for wr_idx");
      assert (WR_W >= ENT_W) else $error("ba_classifier: write data too narrow");
   end

   // ---------------- per-interface configuration words ----------------
   bac_cfg_t cfg_q [IF_CNT];

   for (genvar g = 0; g < IF_CNT; g++) begin : g_cfg
      always_ff @(posedge clk) begin
         if (rst)
            cfg_q[g] <= '0;
         else if (wr_en && wr_sel == WSEL_CFG && wr_idx[IF_W-1:0] == IF_W'(g))
            cfg_q[g] <= bac_cfg_t'(wr_data[CFG_W-1:0]);
      end
   end

   // ---------------- stage 1: code point selection ----------------
   logic adv;
   assign adv      = !out_valid || out_ready;
   assign in_ready = adv;

   bac_src_e            sel_src;
   logic [DSCP_W-1:0]   sel_idx;
   logic [CLS_W-1:0]    sel_dcls;

   bac_keysel u_keysel (
      .cfg        (cfg_q[in_if]),
      .is_ip      (in_is_ip),
      .tags       (in_tags),
      .pcp_outer  (in_pcp_outer),
      .pcp_inner  (in_pcp_inner),
      .prec       (in_prec),
      .dscp       (in_dscp),
      .src        (sel_src),
      .idx        (sel_idx),
      .direct_cls (sel_dcls)
   );

   logic              s1_valid;
   logic [IF_W-1:0]   s1_if;
   bac_src_e          s1_src;
   logic [DSCP_W-1:0] s1_idx;
   logic [CLS_W-1:0]  s1_dcls;
   logic              s1_mf_cls_en;
   logic [CLS_W-1:0]  s1_mf_cls;
   logic              s1_mf_lp_en;
   logic              s1_mf_lp;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_valid     <= 1'b0;
         s1_if        <= '0;
         s1_src       <= SRC_DIRECT;
         s1_idx       <= '0;
         s1_dcls      <= '0;
         s1_mf_cls_en <= 1'b0;
         s1_mf_cls    <= '0;
         s1_mf_lp_en  <= 1'b0;
         s1_mf_lp     <= 1'b0;
      end else if (adv) begin
         s1_valid     <= in_valid;
         s1_if        <= in_if;
         s1_src       <= sel_src;
         s1_idx       <= sel_idx;
         s1_dcls      <= sel_dcls;
         s1_mf_cls_en <= in_mf_cls_en;
         s1_mf_cls    <= in_mf_cls;
         s1_mf_lp_en  <= in_mf_lp_en;
         s1_mf_lp     <= in_mf_lp;
      end
   end

   // ---------------- lookup tables (0 tag-priority, 1 precedence, 2 DSCP) ----------------
   logic [ENT_W-1:0] rd_ent [3];

   for (genvar t = 0; t < 3; t++) begin : g_tbl
      localparam int TW = (t == 2) ? DSCP_W : PCP_W;
      bac_lut #(.IDX_W(TW), .DATA_W(ENT_W)) u_lut (
         .clk    (clk),
         .rst    (rst),
         .we     (wr_en && wr_sel == 2'(t)),
         .w_idx  (wr_idx[TW-1:0]),
         .w_data (wr_data[ENT_W-1:0]),
         .r_idx  (s1_idx[TW-1:0]),
         .r_data (rd_ent[t])
      );
   end

   // ---------------- stage 2: result and override ----------------
   bac_ent_t base;
   always_comb begin
      unique case (s1_src)
         SRC_DOT1P: base = bac_ent_t'(rd_ent[0]);
         SRC_PREC:  base = bac_ent_t'(rd_ent[1]);
         SRC_DSCP:  base = bac_ent_t'(rd_ent[2]);
         default:   base = '{lp: 1'b0, cls: s1_dcls};
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_if    <= '0;
         out_cls   <= '0;
         out_lp    <= 1'b0;
      end else if (adv) begin
         out_valid <= s1_valid;
         out_if    <= s1_if;
         out_cls   <= s1_mf_cls_en ? s1_mf_cls : base.cls;
         out_lp    <= s1_mf_lp_en ? s1_mf_lp : base.lp;
      end
   end

   // ---------------- assertions ----------------
   // R2
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_cls) && $stable(out_lp) && $stable(out_if));
   // R2
   ready_free_chk: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> in_ready);
   // R2
   two_stage_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |-> $past(s1_valid));
   // R9
   mf_cls_chk: assert property (@(posedge clk) disable iff (rst)
      s1_valid && in_ready && s1_mf_cls_en |=> out_cls == $past(s1_mf_cls));
   // R9
   mf_lp_chk: assert property (@(posedge clk) disable iff (rst)
      s1_valid && in_ready && s1_mf_lp_en |=> out_lp == $past(s1_mf_lp));
   // R8
   direct_lp_chk: assert property (@(posedge clk) disable iff (rst)
      s1_valid && in_ready && s1_src == SRC_DIRECT && !s1_mf_lp_en |=> !out_lp);
endmodule

// File: tb/ba_classifier_bench.sv
module ba_classifier_bench;
   logic       clk = 1'b0;
   logic       rst;
   logic       wr_en;
   logic [1:0] wr_sel;
   logic [5:0] wr_idx;
   logic [5:0] wr_data;
   logic       in_valid, in_ready;
   logic [1:0] in_if;
   logic       in_is_ip;
   logic [1:0] in_tags;
   logic [2:0] in_pcp_outer, in_pcp_inner, in_prec;
   logic [5:0] in_dscp;
   logic       in_mf_cls_en;
   logic [2:0] in_mf_cls;
   logic       in_mf_lp_en, in_mf_lp;
   logic       out_valid, out_ready;
   logic [1:0] out_if;
   logic [2:0] out_cls;
   logic       out_lp;

   int total = 0;
   int fails = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   ba_classifier u_ba_classifier (.*);

   // expected table contents, programmed by the bench
   function automatic logic [3:0] d1_ent(int i);
      logic [2:0] v = 3'(i);
      return {v[0], 3'd7 - v};
   endfunction
   function automatic logic [3:0] pr_ent(int i);
      logic [2:0] v = 3'(i);
      return {~v[0], v + 3'd3};
   endfunction
   function automatic logic [3:0] ds_ent(int i);
      logic [5:0] v = 6'(i);
      return {v[1], v[5:3] ^ v[2:0]};
   endfunction

   task automatic chk(input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [5:0] i, input logic [5:0] d);
      wr_en = 1'b1; wr_sel = s; wr_idx = i; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic drive(input logic [1:0] ifn, input logic ip, input logic [1:0] tg,
                        input logic [2:0] po, input logic [2:0] pi, input logic [2:0] pr,
                        input logic [5:0] ds);
      in_valid = 1'b1; in_if = ifn; in_is_ip = ip; in_tags = tg;
      in_pcp_outer = po; in_pcp_inner = pi; in_prec = pr; in_dscp = ds;
      in_mf_cls_en = 1'b0; in_mf_cls = '0; in_mf_lp_en = 1'b0; in_mf_lp = 1'b0;
   endtask

   task automatic classify(input string req, input logic [1:0] ifn, input logic ip,
                           input logic [1:0] tg, input logic [2:0] po, input logic [2:0] pi,
                           input logic [2:0] pr, input logic [5:0] ds,
                           input int ecls, input int elp,
                           input logic mce = 1'b0, input logic [2:0] mc = 3'd0,
                           input logic mle = 1'b0, input logic ml = 1'b0);
      drive(ifn, ip, tg, po, pi, pr, ds);
      in_mf_cls_en = mce; in_mf_cls = mc; in_mf_lp_en = mle; in_mf_lp = ml;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      chk({req, " out_valid"}, int'(out_valid), 1);
      chk({req, " class"}, int'(out_cls), ecls);
      chk({req, " loss priority"}, int'(out_lp), elp);
      chk({req, " interface"}, int'(out_if), int'(ifn));
   endtask

   task automatic t_reset();
      chk("R1 out_valid after reset", int'(out_valid), 0);
      chk("R1 in_ready after reset", int'(in_ready), 1);
      classify("R1 reset config", 2'd0, 1'b1, 2'd2, 3'd4, 3'd5, 3'd6, 6'd33, 0, 0);
      classify("R1 reset config if3", 2'd3, 1'b0, 2'd1, 3'd7, 3'd0, 3'd0, 6'd0, 0, 0);
   endtask

   task automatic t_program();
      for (int i = 0; i < 8; i++) wr(2'd0, 6'(i), {2'b00, d1_ent(i)});
      for (int i = 0; i < 8; i++) wr(2'd1, 6'(i), {2'b00, pr_ent(i)});
      for (int i = 0; i < 64; i++) wr(2'd2, 6'(i), {2'b00, ds_ent(i)});
      wr(2'd3, 6'd0, 6'h05);   // fixed, class 5
      wr(2'd3, 6'd1, 6'h16);   // tag-priority, outer, default 6
      wr(2'd3, 6'd2, 6'h2C);   // mixed precedence, inner, default 4
      wr(2'd3, 6'd3, 6'h32);   // mixed DSCP, outer, default 2
   endtask

   task automatic t_fixed();
      classify("R3 fixed L2", 2'd0, 1'b0, 2'd2, 3'd1, 3'd2, 3'd3, 6'd9, 5, 0);
      classify("R3 fixed IP", 2'd0, 1'b1, 2'd0, 3'd7, 3'd7, 3'd7, 6'd63, 5, 0);
   endtask

   task automatic t_dot1p();
      classify("R4 R10 outer L2", 2'd1, 1'b0, 2'd2, 3'd3, 3'd6, 3'd0, 6'd0,
               int'(d1_ent(3) & 4'h7), int'(d1_ent(3) >> 3));
      classify("R4 outer IP", 2'd1, 1'b1, 2'd1, 3'd6, 3'd1, 3'd5, 6'd46,
               int'(d1_ent(6) & 4'h7), int'(d1_ent(6) >> 3));
      classify("R5 inner dual tag", 2'd2, 1'b0, 2'd2, 3'd1, 3'd6, 3'd0, 6'd0,
               int'(d1_ent(6) & 4'h7), int'(d1_ent(6) >> 3));
   endtask

   task automatic t_mixed();
      classify("R6 precedence IP", 2'd2, 1'b1, 2'd2, 3'd1, 3'd2, 3'd5, 6'd0,
               int'(pr_ent(5) & 4'h7), int'(pr_ent(5) >> 3));
      classify("R7 DSCP IP", 2'd3, 1'b1, 2'd0, 3'd0, 3'd0, 3'd0, 6'd46,
               int'(ds_ent(46) & 4'h7), int'(ds_ent(46) >> 3));
      classify("R7 DSCP if L2", 2'd3, 1'b0, 2'd1, 3'd2, 3'd0, 3'd0, 6'd46,
               int'(d1_ent(2) & 4'h7), int'(d1_ent(2) >> 3));
   endtask

   task automatic t_fallback();
      classify("R8 untagged outer", 2'd1, 1'b0, 2'd0, 3'd3, 3'd3, 3'd0, 6'd0, 6, 0);
      classify("R8 inner single tag", 2'd2, 1'b0, 2'd1, 3'd0, 3'd0, 3'd0, 6'd0, 4, 0);
      classify("R8 untagged mixed DSCP", 2'd3, 1'b0, 2'd0, 3'd1, 3'd0, 3'd0, 6'd0, 2, 0);
   endtask

   task automatic t_override();
      // tag priority 3 -> class 4 loss 1
      classify("R9 class only", 2'd1, 1'b0, 2'd2, 3'd3, 3'd0, 3'd0, 6'd0, 1, 1,
               1'b1, 3'd1, 1'b0, 1'b0);
      classify("R9 loss only", 2'd1, 1'b0, 2'd2, 3'd3, 3'd0, 3'd0, 6'd0, 4, 0,
               1'b0, 3'd7, 1'b1, 1'b0);
      classify("R9 both", 2'd0, 1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 6'd0, 7, 1,
               1'b1, 3'd7, 1'b1, 1'b1);
   endtask

   task automatic t_stream();
      drive(2'd1, 1'b0, 2'd2, 3'd2, 3'd0, 3'd0, 6'd0);
      @(negedge clk);
      drive(2'd1, 1'b0, 2'd2, 3'd3, 3'd0, 3'd0, 6'd0);
      @(negedge clk);
      chk("R2 stream first", int'(out_cls), 5);
      drive(2'd1, 1'b0, 2'd2, 3'd4, 3'd0, 3'd0, 6'd0);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2 stream second", int'(out_cls), 4);
      chk("R2 stream second valid", int'(out_valid), 1);
      @(negedge clk);
      chk("R2 stream third", int'(out_cls), 3);
      @(negedge clk);
      chk("R2 stream drained", int'(out_valid), 0);
   endtask

   task automatic t_stall();
      out_ready = 1'b0;
      drive(2'd1, 1'b0, 2'd2, 3'd0, 3'd0, 3'd0, 6'd0);
      @(negedge clk);
      drive(2'd1, 1'b0, 2'd2, 3'd1, 3'd0, 3'd0, 6'd0);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2 stall in_ready low", int'(in_ready), 0);
      chk("R2 stall first class", int'(out_cls), 7);
      @(negedge clk);
      chk("R2 stall held valid", int'(out_valid), 1);
      chk("R2 stall held class", int'(out_cls), 7);
      chk("R2 stall held loss", int'(out_lp), 0);
      out_ready = 1'b1;
      @(negedge clk);
      chk("R2 release second class", int'(out_cls), 6);
      chk("R2 release second loss", int'(out_lp), 1);
      @(negedge clk);
      chk("R2 release drained", int'(out_valid), 0);
   endtask

   task automatic t_collide();
      // entry 5 currently class 2 loss 1; rewrite while the lookup is in stage 1
      drive(2'd1, 1'b0, 2'd2, 3'd5, 3'd0, 3'd0, 6'd0);
      @(negedge clk);
      in_valid = 1'b0;
      wr_en = 1'b1; wr_sel = 2'd0; wr_idx = 6'd5; wr_data = 6'h03;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R11 in-flight old class", int'(out_cls), 2);
      chk("R11 in-flight old loss", int'(out_lp), 1);
      classify("R11 later new entry", 2'd1, 1'b0, 2'd2, 3'd5, 3'd0, 3'd0, 6'd0, 3, 0);
   endtask

   initial begin
      rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_idx = '0; wr_data = '0;
      in_valid = 1'b0; out_ready = 1'b1;
      drive(2'd0, 1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 6'd0);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_program();
      t_fixed();
      t_dot1p();
      t_mixed();
      t_fallback();
      t_override();
      t_stream();
      t_stall();
      t_collide();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule